// File: doc/BRIEF.md
# Two-Wire Register Port with Auto-Incrementing Pointer

This block is a synchronous target on a two-wire I2C bus that gives a host access to a small register file held elsewhere on the chip. The bus lines arrive oversampled on the system clock. The block resynchronises them, finds START, repeated START and STOP, and checks the 7-bit device address. In a write it takes the first byte as a word pointer and stores every later byte at that pointer. In a read it sends bytes from the pointer, most significant bit first. It acknowledges every byte it receives.

On the chip side the block drives the current pointer as a register address, a write strobe and write data, and reads back one byte of read data combinationally. The pointer advances by one on each acknowledged byte and wraps after the last register, so bursts walk through the file. A read that is not preceded by a pointer write starts from wherever the pointer was left. A power-fail input overrides everything: the transfer is dropped, the pointer goes to zero, and the bus is ignored for as long as the input stays high.

Top module: `i2c_regport`

## Requirements
- R1: A device address byte equal to D0h (write) or D1h (read), with the R/W flag in bit 0, is acknowledged by driving SDA low during the ninth clock.
- R2: After a device address byte with any other value, the block does not acknowledge, issues no register write and keeps SDA released until the next START.
- R3: In a write, the first byte after the device address loads the pointer. Each later byte produces one single-cycle write strobe with that byte at the current pointer address, and each of these bytes is acknowledged.
- R4: The pointer moves up by one on the acknowledge clock of each data byte the target acknowledges, and it wraps from 13h (the last of 20 registers) to 00h.
- R5: After a pointer write, a repeated START with D1h returns the register at the pointer, most significant bit first, followed by the next registers in sequence while the host acknowledges.
- R6: A read that begins with D1h and has no pointer write before it starts at the address the pointer last held.
- R7: When the host does not acknowledge a read byte, the block releases SDA, sends nothing more until the next START, and the pointer does not advance for that byte.
- R8: While the power-fail input is high, any transfer is aborted, SDA is released, the pointer is 00h, and bus activity produces no acknowledge and no write. When the input goes low, the next current-address read starts at 00h.
- R9: A pointer byte of 14h or above loads 00h.
- R10: After reset the pointer is 00h, SDA is released and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_fail | input | 1 | High while supply is out of tolerance; aborts and blocks access |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| rf_addr | output | AW (5) | Current pointer, used as register address |
| rf_wr | output | 1 | One-cycle write strobe |
| rf_wdata | output | 8 | Byte to write at rf_addr |
| rf_rdata | input | 8 | Register contents at rf_addr |

## Verification
The hardest case to reach is a power failure that arrives halfway through a data byte, after the pointer has already been loaded and while the target is still shifting bits in. The bench stops its host model between two bit clocks of a write and raises pwr_fail there. It then runs a complete addressed write while the input is still high, to show that nothing is acknowledged or stored. After the input drops, a current-address read shows that the pointer restarts from zero. Pointer wrap in both directions of transfer is reached by setting the pointer to the last two registers before a burst.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
   localparam int BYTE_W = 8;
   localparam int BITCNT_W = 4;

   typedef enum logic [3:0] {
      S_IDLE,
      S_DEV,
      S_DEV_ACK,
      S_WADDR,
      S_WADDR_ACK,
      S_WDATA,
      S_WDATA_ACK,
      S_RDATA,
      S_RACK
   } xfer_state_t;
endpackage

// File: rtl/i2c_regport_sync.sv
module i2c_regport_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("i2c_regport_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] scl_ff;
   logic [SYNC_STAGES-1:0] sda_ff;
   logic                   scl_d;
   logic                   sda_d;
   logic                   scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
         scl_d  <= scl_ff[SYNC_STAGES-1];
         sda_d  <= sda_ff[SYNC_STAGES-1];
      end
   end

   assign scl_s     = scl_ff[SYNC_STAGES-1];
   assign sda_s     = sda_ff[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_regport_ptr.sv
module i2c_regport_ptr #(
   parameter int DEPTH = 20,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [7:0]    load_val,
   input  logic          inc,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   generate
      if ((1 << AW) < DEPTH) begin : g_bad_aw
         $error("i2c_regport_ptr: AW too narrow for DEPTH");
      end
   endgenerate

   logic in_range;
   assign in_range = ({24'd0, load_val} < DEPTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (clr) begin
         ptr <= '0;
      end else if (load) begin
         ptr <= in_range ? load_val[AW-1:0] : '0;
      end else if (inc) begin
         ptr <= (ptr == LAST) ? '0 : ptr + AW'(1);
      end
   end
endmodule

// File: rtl/i2c_regport_fsm.sv
module i2c_regport_fsm
   import i2c_regport_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h68
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_fail,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] rf_rdata,
   output logic              sda_oe,
   output logic              rf_wr,
   output logic [BYTE_W-1:0] rf_wdata,
   output logic              ptr_load,
   output logic [BYTE_W-1:0] ptr_load_val,
   output logic              ptr_inc
);
   xfer_state_t         st;
   logic [BYTE_W-1:0]   shreg;
   logic [BYTE_W-1:0]   txreg;
   logic [BITCNT_W-1:0] bitcnt;
   logic                rw;
   logic                mack;
   logic                byte_done;
   logic                bus_evt;

   localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);

   assign byte_done    = scl_fall && (bitcnt == LAST_BIT);
   assign bus_evt      = !pwr_fail && !start_det && !stop_det;
   assign ptr_load     = bus_evt && (st == S_WADDR) && byte_done;
   assign ptr_load_val = shreg;
   assign ptr_inc      = bus_evt && scl_rise &&
                         ((st == S_WDATA_ACK) || ((st == S_RACK) && !sda_s));
   assign rf_wdata     = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         shreg  <= '0;
         txreg  <= '0;
         bitcnt <= '0;
         rw     <= 1'b0;
         mack   <= 1'b0;
         sda_oe <= 1'b0;
         rf_wr  <= 1'b0;
      end else if (pwr_fail) begin
         st     <= S_IDLE;
         bitcnt <= '0;
         sda_oe <= 1'b0;
         rf_wr  <= 1'b0;
      end else begin
         rf_wr <= 1'b0;
         if (start_det) begin
            st     <= S_DEV;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            st     <= S_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (st)
               S_IDLE: ;
               S_DEV, S_WADDR, S_WDATA: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + BITCNT_W'(1);
                  end else if (byte_done) begin
                     bitcnt <= '0;
                     if (st == S_DEV) begin
                        if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                           st     <= S_DEV_ACK;
                           rw     <= shreg[0];
                           sda_oe <= 1'b1;
                        end else begin
                           st <= S_IDLE;
                        end
                     end else if (st == S_WADDR) begin
                        st     <= S_WADDR_ACK;
                        sda_oe <= 1'b1;
                     end else begin
                        st     <= S_WDATA_ACK;
                        sda_oe <= 1'b1;
                        rf_wr  <= 1'b1;
                     end
                  end
               end
               S_DEV_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rw) begin
                        st     <= S_RDATA;
                        txreg  <= rf_rdata;
                        sda_oe <= ~rf_rdata[BYTE_W-1];
                     end else begin
                        st     <= S_WADDR;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               S_WADDR_ACK, S_WDATA_ACK: begin
                  if (scl_fall) begin
                     st     <= S_WDATA;
                     bitcnt <= '0;
                     sda_oe <= 1'b0;
                  end
               end
               S_RDATA: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + BITCNT_W'(1);
                  end else if (byte_done) begin
                     st     <= S_RACK;
                     bitcnt <= '0;
                     sda_oe <= 1'b0;
                  end else if (scl_fall) begin
                     txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                     sda_oe <= ~txreg[BYTE_W-2];
                  end
               end
               S_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     bitcnt <= '0;
                     if (mack) begin
                        st     <= S_RDATA;
                        txreg  <= rf_rdata;
                        sda_oe <= ~rf_rdata[BYTE_W-1];
                     end else begin
                        st <= S_IDLE;
                     end
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport #(
   parameter logic [6:0] DEV_ADDR    = 7'h68,
   parameter int         DEPTH       = 20,
   parameter int         SYNC_STAGES = 2,
   parameter int         AW          = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwr_fail,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_oe,
   output logic [AW-1:0] rf_addr,
   output logic          rf_wr,
   output logic [7:0]    rf_wdata,
   input  logic [7:0]    rf_rdata
);
   generate
      if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
         $error("i2c_regport: DEPTH must lie in 2..256");
      end
   endgenerate

   logic       sda_s;
   logic       scl_rise;
   logic       scl_fall;
   logic       start_det;
   logic       stop_det;
   logic       ptr_load;
   logic [7:0] ptr_load_val;
   logic       ptr_inc;

   i2c_regport_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_regport_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .pwr_fail     (pwr_fail),
      .sda_s        (sda_s),
      .scl_rise     (scl_rise),
      .scl_fall     (scl_fall),
      .start_det    (start_det),
      .stop_det     (stop_det),
      .rf_rdata     (rf_rdata),
      .sda_oe       (sda_oe),
      .rf_wr        (rf_wr),
      .rf_wdata     (rf_wdata),
      .ptr_load     (ptr_load),
      .ptr_load_val (ptr_load_val),
      .ptr_inc      (ptr_inc)
   );

   i2c_regport_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (pwr_fail),
      .load     (ptr_load),
      .load_val (ptr_load_val),
      .inc      (ptr_inc),
      .ptr      (rf_addr)
   );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk #(
   parameter int DEPTH = 20,
   parameter int AW    = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pwr_fail,
   input logic          scl_i,
   input logic          sda_oe,
   input logic [AW-1:0] rf_addr,
   input logic          rf_wr
);
   // R4: pointer never leaves the register file
   p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rf_addr < AW'(DEPTH - 1) || rf_addr == AW'(DEPTH - 1));

   // R3: write strobe lasts one cycle
   p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr |=> !rf_wr);

   // R3: a stored byte is acknowledged at the same moment
   p_wr_acked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr |-> sda_oe);

   // R8: power failure releases the bus, clears pointer, blocks writes
   p_pf_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> (!sda_oe && !rf_wr && rf_addr == '0));

   // R1: the target only starts pulling SDA while SCL is low
   p_oe_rise_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i);
endmodule

bind i2c_regport i2c_regport_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pwr_fail (pwr_fail),
   .scl_i    (scl_i),
   .sda_oe   (sda_oe),
   .rf_addr  (rf_addr),
   .rf_wr    (rf_wr)
);

// File: tb/tb_i2c_regport.sv
module tb_i2c_regport;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 8;
   localparam int DEPTH = 20;
   localparam int AW = 5;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          pwr_fail = 0;
   logic          scl = 1;
   logic          sda_m = 1;
   logic          sda_line;
   logic          sda_oe;
   logic [AW-1:0] rf_addr;
   logic          rf_wr;
   logic [7:0]    rf_wdata;
   logic [7:0]    rf_rdata;

   logic [7:0]    mem [DEPTH];
   logic [7:0]    exp_mem [DEPTH];
   logic [12:0]   wq[$];
   int            total = 0;
   int            bad = 0;
   bit            finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;
   assign rf_rdata = mem[rf_addr];

   i2c_regport dut (
      .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
      .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
      .rf_addr(rf_addr), .rf_wr(rf_wr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
   );

   always_ff @(posedge clk) if (rf_wr) mem[rf_addr] <= rf_wdata;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: compare every write strobe with the queued expectation
   always @(negedge clk) begin
      if (rst_n && rf_wr) begin
         if (wq.size() == 0) begin
            check(0, "R2/R8 unexpected write", {rf_addr, rf_wdata}, 0);
         end else begin
            logic [12:0] e;
            e = wq.pop_front();
            check({rf_addr, rf_wdata} == e, "R3 write addr/data", {rf_addr, rf_wdata}, e);
         end
      end
   end

   task automatic bus_wait; repeat (Q) @(negedge clk); endtask
   task automatic do_start;
      sda_m = 1; bus_wait; scl = 1; bus_wait; sda_m = 0; bus_wait; scl = 0; bus_wait;
   endtask
   task automatic do_stop;
      sda_m = 0; bus_wait; scl = 1; bus_wait; sda_m = 1; bus_wait;
   endtask
   task automatic bit_io(input logic b, output logic r);
      sda_m = b; bus_wait; scl = 1; bus_wait; r = sda_line; bus_wait; scl = 0; bus_wait;
   endtask
   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic r;
      for (int i = 7; i >= 0; i--) bit_io(v[i], r);
      bit_io(1'b1, r);
      acked = !r;
   endtask
   task automatic recv_byte(input logic [7:0] exp, input logic give_ack, input string req);
      logic r;
      logic [7:0] v;
      for (int i = 7; i >= 0; i--) begin
         bit_io(1'b1, r);
         v[i] = r;
      end
      bit_io(!give_ack, r);
      check(v == exp, req, v, exp);
   endtask
   // driver: queue an expected write and send the byte
   task automatic wr_byte(input logic [4:0] a, input logic [7:0] d);
      logic ack;
      wq.push_back({a, d});
      exp_mem[a] = d;
      send_byte(d, ack);
      check(ack, "R3 data ack", ack, 1);
   endtask

   initial begin
      logic ack;
      for (int i = 0; i < DEPTH; i++) begin
         mem[i] = 8'h40 + 8'(i);
         exp_mem[i] = 8'h40 + 8'(i);
      end
      repeat (3) @(negedge clk);
      check(sda_oe == 0 && rf_addr == 0 && rf_wr == 0, "R10 reset", {sda_oe, rf_addr, rf_wr}, 0);
      rst_n = 1;
      repeat (3) @(negedge clk);

      // burst write from 03h
      do_start;
      send_byte(8'hD0, ack); check(ack, "R1 write addr ack", ack, 1);
      send_byte(8'h03, ack); check(ack, "R3 pointer ack", ack, 1);
      wr_byte(5'd3, 8'hA1); wr_byte(5'd4, 8'hB2); wr_byte(5'd5, 8'hC3);
      do_stop;
      check(rf_addr == 6, "R4 pointer after burst", rf_addr, 6);

      // write across the wrap
      do_start;
      send_byte(8'hD0, ack);
      send_byte(8'h12, ack);
      wr_byte(5'd18, 8'h11); wr_byte(5'd19, 8'h22); wr_byte(5'd0, 8'h33);
      do_stop;
      check(rf_addr == 1, "R4 write wrap", rf_addr, 1);

      // random read with repeated START, NACK on third byte
      do_start;
      send_byte(8'hD0, ack);
      send_byte(8'h03, ack);
      do_start;
      send_byte(8'hD1, ack); check(ack, "R1 read addr ack", ack, 1);
      recv_byte(exp_mem[3], 1, "R5 read byte0");
      recv_byte(exp_mem[4], 1, "R5 read byte1");
      recv_byte(exp_mem[5], 0, "R5 read byte2");
      repeat (4) @(negedge clk);
      check(sda_oe == 0, "R7 released after nack", sda_oe, 0);
      do_stop;
      check(rf_addr == 5, "R7 no advance on nack", rf_addr, 5);

      // current-address read
      do_start;
      send_byte(8'hD1, ack);
      recv_byte(exp_mem[5], 0, "R6 current read");
      do_stop;

      // read across the wrap
      do_start;
      send_byte(8'hD0, ack);
      send_byte(8'h13, ack);
      do_start;
      send_byte(8'hD1, ack);
      recv_byte(exp_mem[19], 1, "R4 read 13h");
      recv_byte(exp_mem[0], 1, "R4 read wrap 00h");
      recv_byte(exp_mem[1], 0, "R5 read 01h");
      do_stop;
      check(rf_addr == 1, "R4 pointer after read wrap", rf_addr, 1);

      // wrong device address
      do_start;
      send_byte(8'hA0, ack); check(!ack, "R2 no ack", ack, 0);
      send_byte(8'h55, ack); check(!ack, "R2 still released", ack, 0);
      do_stop;
      check(rf_addr == 1, "R2 pointer untouched", rf_addr, 1);

      // out-of-range pointer
      do_start;
      send_byte(8'hD0, ack);
      send_byte(8'h7F, ack); check(ack, "R9 pointer ack", ack, 1);
      wr_byte(5'd0, 8'hEE);
      do_stop;
      check(rf_addr == 1, "R9 clamped then advanced", rf_addr, 1);

      // power failure in the middle of a data byte
      do_start;
      send_byte(8'hD0, ack);
      send_byte(8'h06, ack);
      for (int i = 0; i < 4; i++) bit_io(1'b0, ack);
      pwr_fail = 1;
      repeat (3) @(negedge clk);
      check(rf_addr == 0 && sda_oe == 0, "R8 abort", {sda_oe, rf_addr}, 0);
      do_stop;
      do_start;
      send_byte(8'hD0, ack); check(!ack, "R8 no ack while failing", ack, 0);
      send_byte(8'h05, ack);
      send_byte(8'h99, ack);
      do_stop;
      check(rf_addr == 0, "R8 pointer held at 0", rf_addr, 0);
      pwr_fail = 0;
      repeat (3) @(negedge clk);
      do_start;
      send_byte(8'hD1, ack); check(ack, "R8 ack after recovery", ack, 1);
      recv_byte(exp_mem[0], 0, "R8 read restarts at 00h");
      do_stop;

      repeat (10) @(negedge clk);
      check(wq.size() == 0, "R3 all writes seen", wq.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule